// File: doc/BRIEF.md
# Pipelined Precise Exception Controller

This block is the exception control unit of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). The fetch, decode, execute and memory stages each report their fault conditions together with the PC of the instruction they hold. In the same cycle the unit decides which fault to honour. It then tells the pipeline which stage registers must load a bubble and redirects fetch to a fixed handler address. The winning PC and a cause code go into two architectural registers.

Only the faulting instruction and the younger instructions behind it are squashed. Older instructions further down the pipe keep flowing and retire normally. Register-file and memory write enables of squashed instructions are forced low, so a killed instruction changes no architectural state. The unit tracks the bubble slots it created as they move down the pipe, and it ignores any request that appears in such a slot. A read port, addressed by coprocessor register number, lets a move-from-coprocessor instruction copy the saved PC or the cause into a general register.

All pins are plain control and status signals; no stream interface is involved. The pipeline is assumed to advance one stage every cycle.

Top module: `exc_unit`

## Requirements
- R1: On a taken exception, the saved exception PC holds the PC of the winning instruction from the cycle after detection onward.
- R2: The cause register holds the 5-bit code in bits [6:2], with all other bits zero. Codes by source: fetch page fault 0x14; decode undefined opcode 0x0A; execute overflow 0x0C, with priority over divide-by-zero 0x0F; memory page fault 0x14, with priority over load address error 0x04, which has priority over store address error 0x05.
- R3: When several stages request in one cycle, the oldest stage wins, in the order memory, execute, decode, fetch.
- R4: flush_o (bit 0 fetch, 1 decode, 2 execute, 3 memory) is set in the detection cycle for the winning stage and every younger stage, and is clear for older stages.
- R5: In the detection cycle, pc_load_o is high and pc_target_o equals the handler address (default 0x0000_4000).
- R6: The write-enable outputs (bit 0 decode, 1 execute, 2 memory) are forced low for every squashed stage in the detection cycle, and pass through unchanged for older stages.
- R7: After a take at stage w, the squashed slots move down one stage per cycle: one cycle later they occupy decode through stage w+1, and so on. A request from such a slot is ignored, raises no flush, leaves the saved PC and cause unchanged, and that slot's write enables read low. Stages that are not in a squashed slot are still honoured.
- R8: The saved PC and cause reset to zero and change only when an exception is taken.
- R9: The read port returns the saved PC for address 14, the cause for address 13, and zero for any other address.
- R10: With no live request, flush_o is zero, pc_load_o is low and the write enables pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_pc_i | input | PCW | PC in fetch |
| if_fetch_fault_i | input | 1 | Fetch page fault |
| id_pc_i | input | PCW | PC in decode |
| id_bad_op_i | input | 1 | Undefined or illegal opcode |
| ex_pc_i | input | PCW | PC in execute |
| ex_ovf_i | input | 1 | Arithmetic overflow |
| ex_div0_i | input | 1 | Divide by zero |
| mem_pc_i | input | PCW | PC in memory |
| mem_page_fault_i | input | 1 | Data page fault |
| mem_ld_addr_err_i | input | 1 | Illegal or protected load address |
| mem_st_addr_err_i | input | 1 | Illegal or protected store address |
| rf_we_i | input | 3 | Register-write enables per stage (decode, execute, memory) |
| mem_we_i | input | 3 | Memory-write enables per stage (decode, execute, memory) |
| flush_o | output | 4 | Per-stage squash (fetch..memory) |
| pc_load_o | output | 1 | Load PC with the handler address |
| pc_target_o | output | PCW | Handler address |
| rf_we_o | output | 3 | Gated register-write enables |
| mem_we_o | output | 3 | Gated memory-write enables |
| cp_rd_addr_i | input | 5 | Coprocessor register number to read |
| cp_rd_data_o | output | XLEN | Read data |

## Verification
A wrong winner or a wrong flush mask shows on flush_o and on the gated write enables in the detection cycle itself, with no delay. A corrupted saved PC or cause appears on the read port one cycle after the take. A drifting bubble tracker shows up one to three cycles later: a request in a dead slot is honoured, or a live one is dropped, and flush_o, pc_load_o and the saved PC all change or fail to change in that cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NSTG = 4;               // stages that can fault: IF, ID, EX, MEM
  localparam int CODE_W = 5;
  localparam int CODE_LSB = 2;

  typedef logic [CODE_W-1:0] exc_code_t;

  localparam exc_code_t C_ADDR_LD = 5'h04;
  localparam exc_code_t C_ADDR_ST = 5'h05;
  localparam exc_code_t C_RSVD    = 5'h0A;
  localparam exc_code_t C_OVF     = 5'h0C;
  localparam exc_code_t C_DIV0    = 5'h0F;
  localparam exc_code_t C_PGFLT   = 5'h14;
endpackage

// File: rtl/exc_src_enc.sv
// Folds one stage's fault lines into a request and a code.
// Higher hit index has higher priority.
module exc_src_enc
  import exc_pkg::*;
#(
  parameter int N = 2,
  parameter logic [CODE_W*N-1:0] CODES = '0
) (
  input  logic [N-1:0] hit,
  output logic         req,
  output exc_code_t    code
);
  always_comb begin
    req  = |hit;
    code = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) code = CODES[CODE_W*i +: CODE_W];
    end
  end
endmodule

// File: rtl/exc_arbiter.sv
// Masks requests from squashed slots, selects the oldest live one
// and forms the kill mask for the winner and all younger stages.
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int NS  = NSTG,
  parameter int PCW = 32
) (
  input  logic [NS-1:0]  req,
  input  logic [NS-1:0]  bubble,
  input  exc_code_t      code [NS],
  input  logic [PCW-1:0] pc   [NS],
  output logic           taken,
  output exc_code_t      win_code,
  output logic [PCW-1:0] win_pc,
  output logic [NS-1:0]  kill
);
  logic [NS-1:0] live;
  assign live = req & ~bubble;

  always_comb begin
    taken    = |live;
    win_code = '0;
    win_pc   = '0;
    for (int s = 0; s < NS; s++) begin
      if (live[s]) begin
        win_code = code[s];
        win_pc   = pc[s];
      end
    end
  end

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int s = NS-1; s >= 0; s--) begin
      acc     = acc | live[s];
      kill[s] = acc;
    end
  end
endmodule

// File: rtl/exc_bubble_trk.sv
// Follows squashed slots as they move one stage per cycle.
module exc_bubble_trk #(
  parameter int NS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] kill,
  output logic [NS-1:0] bubble
);
  logic [NS-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= NS'((q | kill) << 1);
  end

  assign bubble = q;
endmodule

// File: rtl/exc_capture.sv
// Saved PC and cause registers plus the coprocessor read port.
module exc_capture
  import exc_pkg::*;
#(
  parameter int         PCW       = 32,
  parameter int         XLEN      = 32,
  parameter logic [4:0] EPC_SEL   = 5'd14,
  parameter logic [4:0] CAUSE_SEL = 5'd13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [PCW-1:0]  win_pc,
  input  exc_code_t       win_code,
  input  logic [4:0]      rd_addr,
  output logic [XLEN-1:0] rd_data,
  output logic [PCW-1:0]  epc_q,
  output logic [XLEN-1:0] cause_q
);
  logic [XLEN-1:0] cause_n;

  always_comb begin
    cause_n = '0;
    cause_n[CODE_LSB +: CODE_W] = win_code;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= '0;
    end else if (take) begin
      epc_q   <= win_pc;
      cause_q <= cause_n;
    end
  end

  always_comb begin
    case (rd_addr)
      EPC_SEL:   rd_data = XLEN'(epc_q);
      CAUSE_SEL: rd_data = cause_q;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/exc_unit.sv
module exc_unit
  import exc_pkg::*;
#(
  parameter int             PCW        = 32,
  parameter int             XLEN       = 32,
  parameter logic [PCW-1:0] HANDLER_PC = PCW'(32'h0000_4000)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PCW-1:0]  if_pc_i,
  input  logic            if_fetch_fault_i,
  input  logic [PCW-1:0]  id_pc_i,
  input  logic            id_bad_op_i,
  input  logic [PCW-1:0]  ex_pc_i,
  input  logic            ex_ovf_i,
  input  logic            ex_div0_i,
  input  logic [PCW-1:0]  mem_pc_i,
  input  logic            mem_page_fault_i,
  input  logic            mem_ld_addr_err_i,
  input  logic            mem_st_addr_err_i,
  input  logic [2:0]      rf_we_i,
  input  logic [2:0]      mem_we_i,
  output logic [3:0]      flush_o,
  output logic            pc_load_o,
  output logic [PCW-1:0]  pc_target_o,
  output logic [2:0]      rf_we_o,
  output logic [2:0]      mem_we_o,
  input  logic [4:0]      cp_rd_addr_i,
  output logic [XLEN-1:0] cp_rd_data_o
);
  localparam int NW = NSTG - 1;  // stages carrying write enables (ID..MEM)

  logic [NSTG-1:0] stg_req, bubble, kill;
  exc_code_t       stg_code [NSTG];
  logic [PCW-1:0]  stg_pc   [NSTG];
  logic            taken;
  exc_code_t       win_code;
  logic [PCW-1:0]  win_pc;
  logic [PCW-1:0]  epc_q;
  logic [XLEN-1:0] cause_q;

  assign stg_pc[0] = if_pc_i;
  assign stg_pc[1] = id_pc_i;
  assign stg_pc[2] = ex_pc_i;
  assign stg_pc[3] = mem_pc_i;

  exc_src_enc #(.N(1), .CODES(C_PGFLT)) u_enc_if (
    .hit(if_fetch_fault_i), .req(stg_req[0]), .code(stg_code[0]));

  exc_src_enc #(.N(1), .CODES(C_RSVD)) u_enc_id (
    .hit(id_bad_op_i), .req(stg_req[1]), .code(stg_code[1]));

  exc_src_enc #(.N(2), .CODES({C_OVF, C_DIV0})) u_enc_ex (
    .hit({ex_ovf_i, ex_div0_i}), .req(stg_req[2]), .code(stg_code[2]));

  exc_src_enc #(.N(3), .CODES({C_PGFLT, C_ADDR_LD, C_ADDR_ST})) u_enc_mem (
    .hit({mem_page_fault_i, mem_ld_addr_err_i, mem_st_addr_err_i}),
    .req(stg_req[3]), .code(stg_code[3]));

  exc_arbiter #(.NS(NSTG), .PCW(PCW)) u_arb (
    .req(stg_req), .bubble(bubble), .code(stg_code), .pc(stg_pc),
    .taken(taken), .win_code(win_code), .win_pc(win_pc), .kill(kill));

  exc_bubble_trk #(.NS(NSTG)) u_trk (
    .clk(clk), .rst_n(rst_n), .kill(kill), .bubble(bubble));

  exc_capture #(.PCW(PCW), .XLEN(XLEN)) u_cap (
    .clk(clk), .rst_n(rst_n), .take(taken), .win_pc(win_pc),
    .win_code(win_code), .rd_addr(cp_rd_addr_i), .rd_data(cp_rd_data_o),
    .epc_q(epc_q), .cause_q(cause_q));

  for (genvar j = 0; j < NW; j++) begin : g_gate
    assign rf_we_o[j]  = rf_we_i[j]  & ~(kill[j+1] | bubble[j+1]);
    assign mem_we_o[j] = mem_we_i[j] & ~(kill[j+1] | bubble[j+1]);
  end

  assign flush_o     = kill;
  assign pc_load_o   = taken;
  assign pc_target_o = HANDLER_PC;
endmodule

// File: rtl/exc_unit_chk.sv
module exc_unit_chk #(
  parameter int             PCW     = 32,
  parameter int             XLEN    = 32,
  parameter logic [PCW-1:0] HANDLER = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_page_fault_i,
  input logic [PCW-1:0]  mem_pc_i,
  input logic [3:0]      flush_o,
  input logic            pc_load_o,
  input logic [PCW-1:0]  pc_target_o,
  input logic [2:0]      rf_we_o,
  input logic [2:0]      mem_we_o,
  input logic [3:0]      bubble,
  input logic [PCW-1:0]  epc_q,
  input logic [XLEN-1:0] cause_q
);
  // R1: a memory-stage take leaves that PC in the saved register
  a_r1_epc_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load_o && flush_o[3]) |=> epc_q == $past(mem_pc_i));

  // R2: only bits [6:2] of the cause may be set
  a_r2_cause_fmt: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q[1:0] == 2'b00) && ((cause_q >> 7) == '0));

  // R3: a live memory request always wins
  a_r3_mem_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_page_fault_i && !bubble[3]) |-> flush_o[3]);

  // R4: flush covers a contiguous range from fetch upward
  a_r4_flush_shape: assert property (@(posedge clk) disable iff (!rst_n)
    ((flush_o + 4'd1) & flush_o) == 4'd0);

  // R5: redirect goes with a fetch flush and the handler address
  a_r5_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |-> (flush_o[0] && pc_target_o == HANDLER));

  // R6: a squashed execute stage writes nothing
  a_r6_ex_gate: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o[2] |-> (!rf_we_o[1] && !mem_we_o[1]));

  // R7: after an execute take, decode holds a bubble next cycle
  a_r7_no_refire: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load_o && flush_o[2]) |=> !flush_o[1]);

  // R8: saved state moves only on a take
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_load_o |=> ($stable(epc_q) && $stable(cause_q)));
endmodule

bind exc_unit exc_unit_chk #(.PCW(PCW), .XLEN(XLEN), .HANDLER(HANDLER_PC)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_page_fault_i(mem_page_fault_i),
  .mem_pc_i(mem_pc_i), .flush_o(flush_o), .pc_load_o(pc_load_o),
  .pc_target_o(pc_target_o), .rf_we_o(rf_we_o), .mem_we_o(mem_we_o),
  .bubble(bubble), .epc_q(epc_q), .cause_q(cause_q));

// File: tb/test_exc_unit.sv
`timescale 1ns/100ps
module test_exc_unit;
  localparam logic [31:0] HND = 32'h0000_4000;
  localparam int NV = 14;
  // [21:15] req {mem_pg, mem_ld, mem_st, ex_ovf, ex_div0, id, if}
  // [14:9]  we  {mem_we[2:0], rf_we[2:0]}
  // [8:5]   expected flush, [4:0] expected code
  localparam logic [21:0] VEC [NV] = '{
    {7'b0000000, 6'b111111, 4'b0000, 5'h00},
    {7'b0000001, 6'b111111, 4'b0001, 5'h14},
    {7'b0000010, 6'b111111, 4'b0011, 5'h0A},
    {7'b0001000, 6'b111111, 4'b0111, 5'h0C},
    {7'b0000100, 6'b101101, 4'b0111, 5'h0F},
    {7'b0001100, 6'b111111, 4'b0111, 5'h0C},
    {7'b1000000, 6'b111111, 4'b1111, 5'h14},
    {7'b0100000, 6'b111111, 4'b1111, 5'h04},
    {7'b0010000, 6'b111111, 4'b1111, 5'h05},
    {7'b0110000, 6'b111111, 4'b1111, 5'h04},
    {7'b1111111, 6'b111111, 4'b1111, 5'h14},
    {7'b0000011, 6'b110110, 4'b0011, 5'h0A},
    {7'b0000111, 6'b111111, 4'b0111, 5'h0F},
    {7'b0011000, 6'b111111, 4'b1111, 5'h05}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] if_pc, id_pc, ex_pc, mem_pc;
  logic        if_f, id_f, ex_o, ex_d, m_pg, m_ld, m_st;
  logic [2:0]  rf_we_i, mem_we_i, rf_we_o, mem_we_o;
  logic [3:0]  flush;
  logic        pc_load;
  logic [31:0] pc_tgt, rd_data;
  logic [4:0]  rd_addr;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  exc_unit i_exc_unit (
    .clk(clk), .rst_n(rst_n),
    .if_pc_i(if_pc), .if_fetch_fault_i(if_f),
    .id_pc_i(id_pc), .id_bad_op_i(id_f),
    .ex_pc_i(ex_pc), .ex_ovf_i(ex_o), .ex_div0_i(ex_d),
    .mem_pc_i(mem_pc), .mem_page_fault_i(m_pg),
    .mem_ld_addr_err_i(m_ld), .mem_st_addr_err_i(m_st),
    .rf_we_i(rf_we_i), .mem_we_i(mem_we_i),
    .flush_o(flush), .pc_load_o(pc_load), .pc_target_o(pc_tgt),
    .rf_we_o(rf_we_o), .mem_we_o(mem_we_o),
    .cp_rd_addr_i(rd_addr), .cp_rd_data_o(rd_data));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set_req(input logic [6:0] r, input logic [5:0] we);
    {m_pg, m_ld, m_st, ex_o, ex_d, id_f, if_f} = r;
    {mem_we_i, rf_we_i} = we;
  endtask

  task automatic idle();
    set_req(7'b0, 6'b0);
  endtask

  task automatic read_saved(input logic [31:0] e_epc, input logic [31:0] e_cause,
                            input string t1, input string t2);
    rd_addr = 5'd14; #0.5;
    chk(t1, rd_data, e_epc);
    rd_addr = 5'd13; #0.5;
    chk(t2, rd_data, e_cause);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_epc, exp_cause;
    logic [31:0] pcs [4];
    pcs[0] = 32'h100; pcs[1] = 32'hFC; pcs[2] = 32'hF8; pcs[3] = 32'hF4;
    if_pc = pcs[0]; id_pc = pcs[1]; ex_pc = pcs[2]; mem_pc = pcs[3];
    idle(); rd_addr = 5'd0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R8: reset values
    read_saved(32'h0, 32'h0, "R8 epc reset", "R8 cause reset");
    chk("R10 reset flush", {28'h0, flush}, 32'h0);
    exp_epc = 0; exp_cause = 0;

    for (int k = 0; k < NV; k++) begin
      logic [3:0] ef;
      logic [5:0] we;
      ef = VEC[k][8:5];
      we = VEC[k][14:9];
      @(negedge clk);
      set_req(VEC[k][21:15], we);
      #1;
      chk(ef == 0 ? "R10 flush" : "R3/R4 flush", {28'h0, flush}, {28'h0, ef});
      chk("R5 pc_load", {31'h0, pc_load}, {31'h0, |ef});
      if (|ef) chk("R5 target", pc_tgt, HND);
      chk("R6 rf_we", {29'h0, rf_we_o}, {29'h0, we[2:0] & ~ef[3:1]});
      chk("R6 mem_we", {29'h0, mem_we_o}, {29'h0, we[5:3] & ~ef[3:1]});
      if (|ef) begin
        for (int s = 0; s < 4; s++) if (ef[s]) exp_epc = pcs[s];
        exp_cause = {25'h0, VEC[k][4:0], 2'b00};
      end
      @(negedge clk);
      idle(); #1;
      read_saved(exp_epc, exp_cause, "R1 epc", "R2 cause");
      repeat (3) @(negedge clk);
    end

    // R9: other register numbers read zero
    rd_addr = 5'd12; #0.5;
    chk("R9 other addr", rd_data, 32'h0);
    rd_addr = 5'd0; #0.5;
    chk("R9 addr zero", rd_data, 32'h0);

    // R7: execute take, then requests in squashed slots
    @(negedge clk);
    ex_pc = 32'h500; ex_o = 1'b1; #1;
    chk("R7 ex take", {28'h0, flush}, 32'h7);
    @(negedge clk);
    idle();
    mem_pc = 32'h5F0; id_pc = 32'h5F8; ex_pc = 32'h5F4;
    m_pg = 1'b1; ex_o = 1'b1; id_f = 1'b1;
    rf_we_i = 3'b111; mem_we_i = 3'b111; #1;
    chk("R7 dead slots flush", {28'h0, flush}, 32'h0);
    chk("R7 dead slots load", {31'h0, pc_load}, 32'h0);
    chk("R7 dead rf_we", {29'h0, rf_we_o}, 32'h0);
    chk("R7 dead mem_we", {29'h0, mem_we_o}, 32'h0);
    @(negedge clk);
    idle(); id_pc = 32'h200; id_f = 1'b1; rf_we_i = 3'b111; #1;
    read_saved(32'h500, {25'h0, 5'h0C, 2'b00}, "R7 epc kept", "R7 cause kept");
    chk("R7 live decode", {28'h0, flush}, 32'h3);
    chk("R7 bubble rf_we", {29'h0, rf_we_o}, 32'h0);
    @(negedge clk);
    idle(); #1;
    read_saved(32'h200, {25'h0, 5'h0A, 2'b00}, "R7 epc new", "R2 cause new");
    repeat (3) @(negedge clk);

    // R7: fetch take, decode slot dead next cycle
    if_pc = 32'h300; if_f = 1'b1; #1;
    chk("R7 if take", {28'h0, flush}, 32'h1);
    @(negedge clk);
    idle(); id_pc = 32'h304; id_f = 1'b1; #1;
    chk("R7 dead decode", {28'h0, flush}, 32'h0);
    @(negedge clk);
    idle(); #1;
    read_saved(32'h300, {25'h0, 5'h14, 2'b00}, "R7 epc after if", "R8 cause held");
    repeat (3) @(negedge clk);

    // R7/R3: fetch take, older memory instruction still honoured
    if_pc = 32'h400; if_f = 1'b1; #1;
    @(negedge clk);
    idle(); mem_pc = 32'h3F4; m_pg = 1'b1; id_f = 1'b1; #1;
    chk("R7 live memory", {28'h0, flush}, 32'hF);
    @(negedge clk);
    idle(); #1;
    read_saved(32'h3F4, {25'h0, 5'h14, 2'b00}, "R1 epc mem", "R2 cause mem");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule